// File: doc/BRIEF.md
# Bi-Quinary Decade Counter

This block is a four-bit decade counter built from two sections that count on their own: a one-bit divide-by-two stage and a three-bit divide-by-five stage. Each section watches its own count input for falling edges, which are found by sampling the input in the system clock and comparing it with the previous sample. The two sections are not joined inside the block.

The user chains them outside the block. If the divide-by-two bit is fed into the second count input, the four output bits step through the decimal digits zero to nine and then return to zero, as in BCD counting. If the two inputs are driven separately, the block gives a divide-by-two and a divide-by-five output side by side.

Two gated controls act on both sections. A pair of clear inputs loads zero when both are high. A pair of preset inputs loads nine when both are high, and it wins over the clear pair. While either pair is active, count edges are dropped.

Top module: `bq_decade_counter`

## Requirements
- R1: After rst_n is released, q_o reads 0000. Bit q_o[0] is the divide-by-two bit and q_o[3:1] is the divide-by-five value, read as an unsigned binary number.
- R2: Each falling edge on cnt_a_i toggles q_o[0] and leaves q_o[3:1] unchanged. A rising edge on cnt_a_i changes nothing.
- R3: Each falling edge on cnt_b_i moves q_o[3:1] one step through 0, 1, 2, 3, 4 and back to 0, and leaves q_o[0] unchanged.
- R4: With q_o[0] fed into cnt_b_i, q_o steps through the values 0 to 9 once per falling edge of cnt_a_i and then returns to 0. It never shows 1010, and q_o[3:1] never exceeds 4.
- R5: When zero0_i and zero1_i are both high, q_o becomes 0000 at the next clock edge, and count edges that occur while both stay high have no effect.
- R6: When only one of zero0_i and zero1_i is high, counting goes on unchanged.
- R7: When nine0_i and nine1_i are both high, q_o becomes 1001 at the next clock edge, even if both clear inputs are also high.
- R8: When only one of nine0_i and nine1_i is high, counting goes on unchanged.
- R9: A falling transition on a count input shows up at q_o on the third rising clock edge after the transition, and not before. This assumes the default of two sampling stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_a_i | input | 1 | Count input of the divide-by-two section, counts on falling edges |
| cnt_b_i | input | 1 | Count input of the divide-by-five section, counts on falling edges |
| zero0_i | input | 1 | First clear-to-zero enable |
| zero1_i | input | 1 | Second clear-to-zero enable |
| nine0_i | input | 1 | First preset-to-nine enable |
| nine1_i | input | 1 | Second preset-to-nine enable |
| q_o | output | HI_W+1 (4) | Bit 0 is the divide-by-two bit; bits 3:1 are the divide-by-five value |

## Verification
The bench builds the counter with its default values: a high-section modulus of 5 and two sampling stages. The two sampling stages fix the delay from an input edge to the output at three clock edges, so the bench can check the exact cycle in which the output changes. A modulus of 5 makes the full decimal wrap from nine to zero reachable within a few dozen count pulses. The bench feeds q_o[0] back into cnt_b_i through a multiplexer in the bench. This lets it run both the cascaded decimal mode and the standalone divide-by-five mode, each against its own reference model.

// File: rtl/bqd_pkg.sv
package bqd_pkg;

    // Action applied to both counter sections in a given cycle.
    typedef enum logic [1:0] {
        CTL_RUN    = 2'd0,
        CTL_CLEAR  = 2'd1,
        CTL_PRESET = 2'd2
    } ctl_e;

    // The preset pair outranks the clear pair. Each pair only acts when both of its inputs are high.
    function automatic ctl_e ctl_decode(input logic z0, input logic z1,
                                        input logic n0, input logic n1);
        if (n0 && n1)      return CTL_PRESET;
        else if (z0 && z1) return CTL_CLEAR;
        else               return CTL_RUN;
    endfunction

endpackage

// File: rtl/bqd_edge_det.sv
module bqd_edge_det #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic fall_o
);

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] sync;
        logic                  prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = in_i;
        for (int i = 1; i < SYNC_DEPTH; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[SYNC_DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A falling edge is a high sample followed by a low sample. The chain resets to low, so reset cannot create an edge.
    assign fall_o = st_q.prev & ~st_q.sync[SYNC_DEPTH-1];

endmodule

// File: rtl/bqd_mod_stage.sv
module bqd_mod_stage
    import bqd_pkg::*;
#(
    parameter int MOD = 5,
    parameter int W   = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctl_e         ctl_i,
    input  logic         step_i,
    output logic [W-1:0] q_o
);

    localparam logic [W-1:0] TOP = W'(MOD - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ctl_i)
            CTL_PRESET: st_d.cnt = TOP;
            CTL_CLEAR:  st_d.cnt = '0;
            default: begin
                if (step_i) begin
                    // Any code at or above the top value wraps to zero, so an illegal code clears on the next step.
                    if (st_q.cnt >= TOP) st_d.cnt = '0;
                    else                 st_d.cnt = st_q.cnt + W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.cnt;

endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
    import bqd_pkg::*;
#(
    parameter int HI_MOD     = 5,
    parameter int SYNC_DEPTH = 2,
    parameter int HI_W       = $clog2(HI_MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_a_i,
    input  logic          cnt_b_i,
    input  logic          zero0_i,
    input  logic          zero1_i,
    input  logic          nine0_i,
    input  logic          nine1_i,
    output logic [HI_W:0] q_o
);

    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] fall;
    ctl_e            ctl;
    logic            lo_q;
    logic [HI_W-1:0] hi_q;

    assign raw_in = {cnt_b_i, cnt_a_i};
    assign ctl    = ctl_decode(zero0_i, zero1_i, nine0_i, nine1_i);

    for (genvar g = 0; g < N_IN; g++) begin : g_edge
        bqd_edge_det #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_i   (raw_in[g]),
            .fall_o (fall[g])
        );
    end

    bqd_mod_stage #(.MOD(2), .W(1)) u_div2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl),
        .step_i (fall[0]),
        .q_o    (lo_q)
    );

    bqd_mod_stage #(.MOD(HI_MOD), .W(HI_W)) u_div5 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl),
        .step_i (fall[1]),
        .q_o    (hi_q)
    );

    assign q_o = {hi_q, lo_q};

endmodule

// File: rtl/bqd_counter_chk.sv
module bqd_counter_chk #(
    parameter int HI_MOD = 5,
    parameter int HI_W   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          zero0_i,
    input logic          zero1_i,
    input logic          nine0_i,
    input logic          nine1_i,
    input logic [HI_W:0] q_o
);

    localparam logic [HI_W:0] NINE = {HI_W'(HI_MOD - 1), 1'b1};

    function automatic logic [HI_W-1:0] hi_step(input logic [HI_W-1:0] v);
        return (v >= HI_W'(HI_MOD - 1)) ? '0 : v + HI_W'(1);
    endfunction

    // R7
    preset_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nine0_i && nine1_i) |=> (q_o == NINE));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero0_i && zero1_i && !(nine0_i && nine1_i)) |=> (q_o == '0));

    // R4
    hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o[HI_W:1] < HI_W'(HI_MOD)));

    // R3
    hi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(zero0_i && zero1_i) && !(nine0_i && nine1_i)) |=>
        ((q_o[HI_W:1] == $past(q_o[HI_W:1])) ||
         (q_o[HI_W:1] == hi_step($past(q_o[HI_W:1])))));

endmodule

bind bq_decade_counter bqd_counter_chk #(.HI_MOD(HI_MOD), .HI_W(HI_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .zero0_i (zero0_i),
    .zero1_i (zero1_i),
    .nine0_i (nine0_i),
    .nine1_i (nine1_i),
    .q_o     (q_o)
);

// File: tb/test_bq_decade_counter.sv
`timescale 1ns/1ps
module test_bq_decade_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a = 1'b0, b_tb = 1'b0, cascade = 1'b0;
    logic       z0 = 1'b0, z1 = 1'b0, n0 = 1'b0, n1 = 1'b0;
    logic       b_drv;
    logic [3:0] q;
    int         checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    assign b_drv = cascade ? q[0] : b_tb;

    bq_decade_counter i_bq_decade_counter (
        .clk(clk), .rst_n(rst_n), .cnt_a_i(a), .cnt_b_i(b_drv),
        .zero0_i(z0), .zero1_i(z1), .nine0_i(n0), .nine1_i(n1), .q_o(q)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_a();
        a = 1'b1; wait_clk(5);
        a = 1'b0; wait_clk(10);
    endtask

    task automatic pulse_b();
        b_tb = 1'b1; wait_clk(5);
        b_tb = 1'b0; wait_clk(6);
    endtask

    task automatic do_clear();
        z0 = 1'b1; z1 = 1'b1; wait_clk(8);
        z0 = 1'b0; z1 = 1'b0; wait_clk(2);
    endtask

    task automatic t_reset();
        wait_clk(3);
        rst_n = 1'b1; wait_clk(3);
        check("R1 reset value", q, 4'b0000);
    endtask

    task automatic t_latency();
        do_clear();
        a = 1'b1; wait_clk(6);
        @(posedge clk); #1 a = 1'b0;
        wait_clk(2);
        check("R9 no change before third edge", q, 4'b0000);
        wait_clk(1);
        check("R9 change on third edge", q, 4'b0001);
        wait_clk(4);
    endtask

    task automatic t_div2();
        logic [3:0] exp = 4'b0000;
        do_clear();
        for (int i = 0; i < 4; i++) begin
            pulse_a();
            exp[0] = ~exp[0];
            check("R2 toggle on falling A", q, exp);
        end
        a = 1'b1; wait_clk(8);
        check("R2 rising A no effect", q, exp);
        a = 1'b0; wait_clk(8);
    endtask

    task automatic t_div5();
        int hi = 0;
        do_clear();
        for (int i = 0; i < 12; i++) begin
            pulse_b();
            hi = (hi + 1) % 5;
            check("R3 divide-by-five step", q, {3'(hi), 1'b0});
        end
    endtask

    task automatic t_cascade();
        int exp = 0;
        do_clear();
        cascade = 1'b1;
        for (int i = 0; i < 25; i++) begin
            pulse_a();
            exp = (exp + 1) % 10;
            check("R4 cascaded decimal count", q, 4'(exp));
            if (q == 4'b1010) check("R4 state 1010 shown", q, 4'b0000);
        end
        z0 = 1'b1; z1 = 1'b1; wait_clk(2);
        cascade = 1'b0; wait_clk(8);
        z0 = 1'b0; z1 = 1'b0; wait_clk(2);
        check("R5 clear after cascade", q, 4'b0000);
    endtask

    task automatic t_clear();
        do_clear();
        pulse_b(); pulse_b(); pulse_a();
        check("R3 setup count", q, 4'b0101);
        z0 = 1'b1; pulse_a();
        check("R6 single clear ignored on A", q, 4'b0100);
        z0 = 1'b0; z1 = 1'b1; pulse_b();
        check("R6 single clear ignored on B", q, 4'b0110);
        z0 = 1'b1; wait_clk(1);
        check("R5 both clear gives zero", q, 4'b0000);
        pulse_a(); pulse_b();
        check("R5 edges blocked while clear held", q, 4'b0000);
        z0 = 1'b0; z1 = 1'b0; wait_clk(6);
        check("R5 zero after release", q, 4'b0000);
    endtask

    task automatic t_preset();
        do_clear();
        n0 = 1'b1; n1 = 1'b1; wait_clk(1);
        check("R7 preset gives nine", q, 4'b1001);
        z0 = 1'b1; z1 = 1'b1; wait_clk(3);
        check("R7 preset wins over clear", q, 4'b1001);
        pulse_a();
        check("R7 edges blocked while preset held", q, 4'b1001);
        z0 = 1'b0; z1 = 1'b0; n1 = 1'b0; wait_clk(4);
        pulse_a();
        check("R8 single preset ignored on A", q, 4'b1000);
        n0 = 1'b0; n1 = 1'b1; pulse_b();
        check("R8 single preset ignored on B, wrap 4 to 0", q, 4'b0000);
        n1 = 1'b0; wait_clk(2);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_div2();
        t_div5();
        t_cascade();
        t_clear();
        t_preset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog expired got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule